// File: doc/BRIEF.md
# CCD Sample and Clamp Pulse Conditioner

This block sits between the timing generator of an image sensor front end and the analog sampling stage. Four externally timed pulses come in, each with a configurable active level: the reference-level sample pulse, the data-level sample pulse, the black-pixel clamp pulse and the dummy-pixel clamp pulse. The block turns them into active-high enables with no register in their path. It qualifies the dummy-pixel clamp with the reference sample pulse. It qualifies the black clamp loop with the blanking input and flags a black clamp request that arrives while blanking is in force.

A sleep input forces every pulse line to its idle internal state and holds the conversion clock high. On a fast oversampling clock, the block also makes one-cycle hold strobes at the trailing edges of the two sample enables. These mark the instants when the reference and data levels are held. A 4-bit level code is turned into the 12-bit black clamp target.

Top module: `ccd_pulse_cond`

## Requirements
- R1: The dummy pulse polarity is set by pol_i[0]: 0 means the pulse is active when low, 1 means active when high.
- R2: The black clamp pulse polarity is set by pol_i[1], with the same encoding as R1.
- R3: pol_i[2] sets one polarity shared by the reference and data sample pulses, encoded as in R1. ref_sample_en_o and data_sample_en_o are high exactly while the corresponding pulse is active and sleep_i is low, in the same cycle and with no register delay.
- R4: dummy_clamp_en_o is high only when the dummy pulse and the reference sample pulse are both active and sleep_i is low.
- R5: ob_clamp_en_o is high when the black clamp pulse is active, blank_n_i is high and sleep_i is low. ob_pblk_warn_o is high when the black clamp pulse is active, blank_n_i is low and sleep_i is low.
- R6: While sleep_i is high, all enables, the warning and both hold strobes are low and conv_clk_o is high, whatever the pulse inputs do.
- R7: While sleep_i is low, conv_clk_o follows conv_clk_i combinationally.
- R8: black_target_o equals 2 + 16 × level_i, so code 0 gives 2, code 8 gives 130 and code 15 gives 242.
- R9: ref_hold_o is high for exactly the one clock cycle in which ref_sample_en_o is low after being high at the previous rising clock edge, and only while sleep_i is low.
- R10: data_hold_o behaves as in R9 for data_sample_en_o.
- R11: After reset the edge history is cleared, so no hold strobe occurs until a sample enable has been seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock for the edge detectors |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse_i | input | 1 | Raw reference-level sample pulse |
| data_pulse_i | input | 1 | Raw data-level sample pulse |
| black_pulse_i | input | 1 | Raw black-pixel clamp pulse |
| dummy_pulse_i | input | 1 | Raw dummy-pixel clamp pulse |
| conv_clk_i | input | 1 | Conversion clock to be gated |
| blank_n_i | input | 1 | Low while input blanking is in force |
| sleep_i | input | 1 | Standby: mask all pulses |
| pol_i | input | 3 | Polarity bits: [0] dummy, [1] black, [2] both sample pulses |
| level_i | input | 4 | Black clamp level code |
| ref_sample_en_o | output | 1 | Active-high reference sample enable |
| data_sample_en_o | output | 1 | Active-high data sample enable |
| ob_clamp_en_o | output | 1 | Black clamp loop enable |
| dummy_clamp_en_o | output | 1 | Input (dummy-pixel) clamp enable |
| ob_pblk_warn_o | output | 1 | Black clamp requested during blanking |
| conv_clk_o | output | 1 | Gated conversion clock |
| ref_hold_o | output | 1 | One-cycle strobe at reference sample trailing edge |
| data_hold_o | output | 1 | One-cycle strobe at data sample trailing edge |
| black_target_o | output | 12 | Black clamp target in LSBs |

## Verification
On every cycle the assertions check the following: the dummy clamp never fires without the reference sample enable, the black clamp enable and the blanking warning never occur together, sleep silences every output and holds the clock high, and each hold strobe lasts one cycle and follows a cycle where its enable was high. Only the bench's reference model can show the polarity mapping of each pulse group, the exact level-to-target arithmetic across all sixteen codes, and whether a strobe appears on every trailing edge and nowhere else. The model compares all outputs each cycle over directed polarity sweeps and a long run of random pulse patterns, including sleep entered and left while pulses are active.

// File: rtl/ccd_pulse_pkg.sv
package ccd_pulse_pkg;
   // channel order used by the normalizer and strobe generator
   typedef enum logic [1:0] {
      CH_REF   = 2'd0,
      CH_DATA  = 2'd1,
      CH_BLACK = 2'd2,
      CH_DUMMY = 2'd3
   } pulse_ch_e;

   localparam int unsigned NUM_CH = 4;

   // clamp target: base plus step per code unit
   function automatic logic [31:0] clamp_target(input logic [31:0] code,
                                                input int unsigned base,
                                                input int unsigned step);
      return 32'(base) + code * 32'(step);
   endfunction
endpackage

// File: rtl/pulse_polarity.sv
module pulse_polarity #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] raw_i,
   input  logic [N-1:0] act_high_i,
   input  logic         mask_i,
   output logic [N-1:0] act_o
);
   for (genvar g = 0; g < N; g++) begin : g_ch
      // active when raw level matches the selected active level
      assign act_o[g] = ~(raw_i[g] ^ act_high_i[g]) & ~mask_i;
   end
endmodule

// File: rtl/trail_strobe.sv
module trail_strobe #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level_i,
   input  logic         quiet_i,
   output logic [N-1:0] strobe_o
);
   logic [N-1:0] seen_q;

   for (genvar g = 0; g < N; g++) begin : g_det
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen_q[g] <= 1'b0;
         else        seen_q[g] <= level_i[g];
      end
      assign strobe_o[g] = seen_q[g] & ~level_i[g] & ~quiet_i;
   end
endmodule

// File: rtl/ccd_pulse_cond.sv
module ccd_pulse_cond #(
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned TGT_W    = 12,
   parameter int unsigned TGT_BASE = 2,
   parameter int unsigned TGT_STEP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_pulse_i,
   input  logic              data_pulse_i,
   input  logic              black_pulse_i,
   input  logic              dummy_pulse_i,
   input  logic              conv_clk_i,
   input  logic              blank_n_i,
   input  logic              sleep_i,
   input  logic [2:0]        pol_i,
   input  logic [CODE_W-1:0] level_i,
   output logic              ref_sample_en_o,
   output logic              data_sample_en_o,
   output logic              ob_clamp_en_o,
   output logic              dummy_clamp_en_o,
   output logic              ob_pblk_warn_o,
   output logic              conv_clk_o,
   output logic              ref_hold_o,
   output logic              data_hold_o,
   output logic [TGT_W-1:0]  black_target_o
);
   import ccd_pulse_pkg::*;

   localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;
   localparam int unsigned MAX_TGT  = TGT_BASE + TGT_STEP * MAX_CODE;

   if (MAX_TGT >= (1 << TGT_W)) begin : g_bad_target
      $error("clamp target range exceeds TGT_W");
   end

   logic [NUM_CH-1:0] raw, act_high, act;
   logic [1:0]        strobes;

   assign raw[CH_REF]        = ref_pulse_i;
   assign raw[CH_DATA]       = data_pulse_i;
   assign raw[CH_BLACK]      = black_pulse_i;
   assign raw[CH_DUMMY]      = dummy_pulse_i;
   assign act_high[CH_REF]   = pol_i[2];
   assign act_high[CH_DATA]  = pol_i[2];
   assign act_high[CH_BLACK] = pol_i[1];
   assign act_high[CH_DUMMY] = pol_i[0];

   pulse_polarity #(.N(NUM_CH)) i_pol (
      .raw_i      (raw),
      .act_high_i (act_high),
      .mask_i     (sleep_i),
      .act_o      (act)
   );

   assign ref_sample_en_o  = act[CH_REF];
   assign data_sample_en_o = act[CH_DATA];
   assign dummy_clamp_en_o = act[CH_DUMMY] & act[CH_REF];
   assign ob_clamp_en_o    = act[CH_BLACK] & blank_n_i;
   assign ob_pblk_warn_o   = act[CH_BLACK] & ~blank_n_i;
   assign conv_clk_o       = conv_clk_i | sleep_i;

   trail_strobe #(.N(2)) i_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  ({act[CH_DATA], act[CH_REF]}),
      .quiet_i  (sleep_i),
      .strobe_o (strobes)
   );

   assign ref_hold_o  = strobes[0];
   assign data_hold_o = strobes[1];

   logic [31:0] tgt_full;
   assign tgt_full       = clamp_target(32'(level_i), TGT_BASE, TGT_STEP);
   assign black_target_o = tgt_full[TGT_W-1:0];
endmodule

// File: rtl/ccd_pulse_cond_chk.sv
module ccd_pulse_cond_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_i,
   input logic ref_sample_en_o,
   input logic data_sample_en_o,
   input logic ob_clamp_en_o,
   input logic dummy_clamp_en_o,
   input logic ob_pblk_warn_o,
   input logic conv_clk_o,
   input logic ref_hold_o,
   input logic data_hold_o
);
   p_dummy_needs_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dummy_clamp_en_o |-> ref_sample_en_o);

   p_ob_warn_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ob_clamp_en_o, ob_pblk_warn_o}));

   p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (conv_clk_o && !ref_sample_en_o && !data_sample_en_o &&
                   !ob_clamp_en_o && !dummy_clamp_en_o && !ob_pblk_warn_o &&
                   !ref_hold_o && !data_hold_o));

   p_ref_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_hold_o |=> !ref_hold_o);

   p_ref_strobe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_hold_o |-> (!ref_sample_en_o && $past(ref_sample_en_o)));

   p_data_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      data_hold_o |=> !data_hold_o);

   p_data_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      data_hold_o |-> (!data_sample_en_o && $past(data_sample_en_o)));
endmodule

bind ccd_pulse_cond ccd_pulse_cond_chk i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .sleep_i          (sleep_i),
   .ref_sample_en_o  (ref_sample_en_o),
   .data_sample_en_o (data_sample_en_o),
   .ob_clamp_en_o    (ob_clamp_en_o),
   .dummy_clamp_en_o (dummy_clamp_en_o),
   .ob_pblk_warn_o   (ob_pblk_warn_o),
   .conv_clk_o       (conv_clk_o),
   .ref_hold_o       (ref_hold_o),
   .data_hold_o      (data_hold_o)
);

// File: tb/test_ccd_pulse_cond.sv
module test_ccd_pulse_cond;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_p = 1'b1, data_p = 1'b1, black_p = 1'b1, dummy_p = 1'b1;
   logic cclk = 1'b0, blank_n = 1'b1, sleep = 1'b0;
   logic [2:0] pol = 3'b000;
   logic [3:0] level = 4'd8;
   logic ref_en, data_en, ob_en, dm_en, warn, cclk_o, ref_hold, data_hold;
   logic [11:0] target;

   int n_checks = 0;
   int n_fail = 0;
   bit prev_ref = 0, prev_data = 0;

   always #2.5 clk = ~clk;

   ccd_pulse_cond i_ccd_pulse_cond (
      .clk(clk), .rst_n(rst_n),
      .ref_pulse_i(ref_p), .data_pulse_i(data_p),
      .black_pulse_i(black_p), .dummy_pulse_i(dummy_p),
      .conv_clk_i(cclk), .blank_n_i(blank_n), .sleep_i(sleep),
      .pol_i(pol), .level_i(level),
      .ref_sample_en_o(ref_en), .data_sample_en_o(data_en),
      .ob_clamp_en_o(ob_en), .dummy_clamp_en_o(dm_en),
      .ob_pblk_warn_o(warn), .conv_clk_o(cclk_o),
      .ref_hold_o(ref_hold), .data_hold_o(data_hold),
      .black_target_o(target)
   );

   function automatic bit is_act(bit raw, bit hi);
      return hi ? raw : !raw;
   endfunction

   function automatic bit exp_ref();  return is_act(ref_p,  pol[2]) && !sleep; endfunction
   function automatic bit exp_data(); return is_act(data_p, pol[2]) && !sleep; endfunction
   function automatic bit exp_blk();  return is_act(black_p, pol[1]) && !sleep; endfunction
   function automatic bit exp_dm();   return is_act(dummy_p, pol[0]) && !sleep; endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // edge history of the reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ref  <= 0;
         prev_data <= 0;
      end else begin
         prev_ref  <= exp_ref();
         prev_data <= exp_data();
      end
   end

   // compare every cycle at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_ref, e_dat, e_blk, e_dm;
         int e_tgt;
         e_ref = exp_ref(); e_dat = exp_data(); e_blk = exp_blk(); e_dm = exp_dm();
         e_tgt = 2 + 16 * int'(level);
         check(ref_en == e_ref, "R3 ref enable", ref_en, e_ref);
         check(data_en == e_dat, "R3 data enable", data_en, e_dat);
         check(dm_en == (e_dm && e_ref), "R1 R4 dummy clamp", dm_en, e_dm && e_ref);
         check(ob_en == (e_blk && blank_n), "R2 R5 black clamp", ob_en, e_blk && blank_n);
         check(warn == (e_blk && !blank_n), "R5 blank warning", warn, e_blk && !blank_n);
         check(cclk_o == (sleep ? 1'b1 : cclk), "R6 R7 conv clock", cclk_o, sleep ? 1 : cclk);
         check(int'(target) == e_tgt, "R8 target", target, e_tgt);
         check(ref_hold == (prev_ref && !e_ref && !sleep), "R9 ref strobe",
               ref_hold, prev_ref && !e_ref && !sleep);
         check(data_hold == (prev_data && !e_dat && !sleep), "R10 data strobe",
               data_hold, prev_data && !e_dat && !sleep);
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      #1;
      // R11: reset state, default polarity idle-high pulses inactive
      check(ref_hold == 0 && data_hold == 0, "R11 strobes after reset", ref_hold, 0);
      check(ref_en == 0, "R3 reset idle enable", ref_en, 0);
      // R1..R3: drive each group active in both polarities
      for (int p = 0; p < 8; p++) begin
         pol = 3'(p);
         ref_p = pol[2]; data_p = pol[2]; black_p = pol[1]; dummy_p = pol[0];
         step(2);
         ref_p = !pol[2]; step(1);
         data_p = !pol[2]; step(1);
         black_p = !pol[1]; dummy_p = !pol[0]; step(1);
      end
      // R5: black clamp during blanking
      pol = 3'b000; black_p = 0; blank_n = 0; step(2); blank_n = 1; step(2);
      // R6: sleep entered while pulses active, then left
      ref_p = 0; data_p = 0; dummy_p = 0; step(2);
      sleep = 1; step(3); cclk = 0; step(1);
      sleep = 0; step(2);
      // R8: all level codes
      for (int c = 0; c < 16; c++) begin
         level = 4'(c); step(1);
      end
      // random patterns
      for (int i = 0; i < 4000; i++) begin
         logic [11:0] r;
         r = 12'($urandom);
         ref_p = r[0]; data_p = r[1]; black_p = r[2]; dummy_p = r[3];
         cclk = r[4]; blank_n = r[5] | r[6];
         sleep = (r[7] & r[8] & r[9]);
         if (i % 500 == 0) pol = 3'($urandom);
         level = 4'($urandom);
         step(1);
      end
      // R11: reset mid-run clears history
      ref_p = 0; pol = 3'b000; sleep = 0; step(2);
      rst_n = 0; step(1); ref_p = 1; rst_n = 1; #1;
      check(ref_hold == 0, "R11 strobe after mid-run reset", ref_hold, 0);
      step(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule